// File: doc/BRIEF.md
# In-Order Issue and Stall Controller

This block decides, cycle by cycle, when the next decoded instruction may leave decode and enter the execute stage of a five-stage in-order pipeline: fetch, decode, execute, memory, writeback. The execute stage mixes three kinds of unit: single-cycle operations, a three-cycle multiplier that accepts a new operation every cycle, and a five-cycle divider that accepts nothing new while it is busy. Instructions come in over a valid/ready handshake. Each one carries an operation class, a destination register and two source registers. Datapath values, memory and register contents are outside the block. It only handles timing.

A per-register scoreboard records the cycle in which each pending result can be forwarded. An instruction waits in decode until both of its sources are available and the divider is free, if it needs the divider. It also waits until its writeback slot falls after the previous instruction's writeback, so that completion stays in program order with at most one retirement per cycle. While it waits, the input sees ready low and execute receives a bubble. A mode input switches to serial operation: the next instruction is fetched only after the previous one has left writeback. The block counts issued and retired instructions. Once the stream's last instruction has retired, it reports the total cycle count from the first fetch to the last writeback and raises a done flag.

Top module: `issue_ctrl`

## Requirements
- R1: After reset: `in_ready` is 1, `issue_pulse`, `retire_pulse` and `done` are 0, and `issue_count` and `retire_count` are 0.
- R2: The class encoding is 0 = single-cycle ALU, 1 = multiply, 2 = divide, 3 = load. Execute takes 1, 3, 5 and 1 cycles for these classes. A stream of N independent ALU instructions issues one per cycle and has a total of N+4 cycles.
- R3: Independent multiplies issue on consecutive cycles.
- R4: Two divide issues are always at least 5 cycles apart. Independent back-to-back divides are exactly 5 cycles apart.
- R5: An instruction that reads the destination of an earlier multiply issues 3 cycles after it. One that reads the result of a load issues 2 cycles after the load.
- R6: Retirement is in program order, at most one per cycle. An instruction that follows a longer-latency one is held so that it retires exactly one cycle after it. An independent ALU instruction after a multiply therefore issues 3 cycles after the multiply.
- R7: While the instruction in decode cannot issue, `in_ready` is 0. Each such cycle with `in_valid` high is a lost fetch cycle.
- R8: With `serial_mode` = 1, a new instruction is accepted only when nothing is in flight. The total is then the sum over all instructions of (4 + execute latency).
- R9: After the stream, `issue_count` and `retire_count` both equal the number of instructions, and `retire_count` never exceeds `issue_count`. `cycle_total` equals the number of cycles from the first fetch (cycle 0) through the last writeback cycle inclusive.
- R10: Once the instruction flagged by `in_last` has been accepted, `in_ready` stays 0. `done` rises after that instruction retires and holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 = one instruction in flight at a time |
| in_valid | input | 1 | Instruction offered |
| in_class | input | 2 | Operation class (0 ALU, 1 MUL, 2 DIV, 3 LOAD) |
| in_dst | input | 4 | Destination register |
| in_src_a | input | 4 | First source register |
| in_src_b | input | 4 | Second source register |
| in_last | input | 1 | Marks the final instruction of the stream |
| in_ready | output | 1 | Instruction accepted when high with `in_valid` |
| issue_pulse | output | 1 | Decode instruction enters execute next cycle |
| retire_pulse | output | 1 | An instruction is in writeback this cycle |
| issue_count | output | CW | Instructions issued |
| retire_count | output | CW | Instructions retired |
| cycle_total | output | CW | First fetch to last writeback, valid with `done` |
| done | output | 1 | Stream complete |

## Verification
The assertions rely on three things about the inputs: `serial_mode` stays constant for a whole stream, a stream ends with exactly one `in_last`, and a new stream begins only after a reset, since the cycle counter and the scoreboard are not cleared any other way. The bench resets the block before every scenario and holds the mode fixed across each run. It offers instructions back to back, marks only the final one as last, and then drops `in_valid`. Under these conditions the divide spacing, the serial-mode exclusion and the sticky done flag can be checked as properties, while the bench's own timing model predicts the exact issue and retire cycles.

// File: rtl/issue_pkg.sv
package issue_pkg;

    localparam int REG_W    = 4;
    localparam int NUM_REGS = 1 << REG_W;
    localparam int DIV_LAT  = 5;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_MUL  = 2'd1,
        OP_DIV  = 2'd2,
        OP_LOAD = 2'd3
    } op_class_e;

    typedef struct packed {
        op_class_e        cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
    } dec_slot_t;

    // cycles spent in execute
    function automatic logic [2:0] exec_lat(op_class_e c);
        case (c)
            OP_MUL:  return 3'd3;
            OP_DIV:  return 3'd5;
            default: return 3'd1;
        endcase
    endfunction

    // extra cycles before forwarding (loads forward after memory)
    function automatic logic [1:0] fwd_extra(op_class_e c);
        return (c == OP_LOAD) ? 2'd1 : 2'd0;
    endfunction

endpackage

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import issue_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rd_a,
    input  logic [REG_W-1:0] rd_b,
    output logic [CW-1:0]    avail_a,
    output logic [CW-1:0]    avail_b,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_idx,
    input  logic [CW-1:0]    wr_stamp
);

    logic [CW-1:0] stamp [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    stamp[r] <= '0;
                else if (wr_en && wr_idx == REG_W'(r))
                    stamp[r] <= wr_stamp;
            end
        end
    endgenerate

    assign avail_a = stamp[rd_a];
    assign avail_b = stamp[rd_b];

endmodule

// File: rtl/issue_retire_queue.sv
module issue_retire_queue #(
    parameter int CW    = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [CW-1:0] push_stamp,
    input  logic [CW-1:0] now,
    output logic          pop,
    output logic          empty,
    output logic          full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CW-1:0] slots [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign pop   = !empty && (slots[rd_ptr] == now);

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_stamp;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop)
                rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/issue_hazard.sv
module issue_hazard
    import issue_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          slot_valid,
    input  op_class_e     slot_cls,
    input  logic [CW-1:0] now,
    input  logic [CW-1:0] avail_a,
    input  logic [CW-1:0] avail_b,
    input  logic [CW-1:0] div_free_at,
    input  logic [CW-1:0] last_wb,
    output logic          go,
    output logic [CW-1:0] wb_stamp,
    output logic [CW-1:0] fwd_stamp,
    output logic [CW-1:0] div_busy_until
);

    logic [CW-1:0] t_exec, lat;
    logic          src_ok, div_ok, order_ok;

    always_comb begin
        t_exec         = now + CW'(1);
        lat            = CW'(exec_lat(slot_cls));
        wb_stamp       = t_exec + lat + CW'(1);
        fwd_stamp      = t_exec + lat + CW'(fwd_extra(slot_cls));
        div_busy_until = t_exec + CW'(DIV_LAT);
        src_ok         = (avail_a <= t_exec) && (avail_b <= t_exec);
        div_ok         = (slot_cls != OP_DIV) || (div_free_at <= t_exec);
        order_ok       = (wb_stamp > last_wb);
        go             = slot_valid && src_ok && div_ok && order_ok;
    end

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
    import issue_pkg::*;
#(
    parameter int CW     = 16,
    parameter int QDEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          serial_mode,
    input  logic          in_valid,
    input  logic [1:0]    in_class,
    input  logic [3:0]    in_dst,
    input  logic [3:0]    in_src_a,
    input  logic [3:0]    in_src_b,
    input  logic          in_last,
    output logic          in_ready,
    output logic          issue_pulse,
    output logic          retire_pulse,
    output logic [CW-1:0] issue_count,
    output logic [CW-1:0] retire_count,
    output logic [CW-1:0] cycle_total,
    output logic          done
);

    dec_slot_t     d_q;
    op_class_e     slot_cls;
    logic          d_valid, last_taken, running, done_q;
    logic [CW-1:0] cyc, div_free_q, last_wb_q, total_q;
    logic [CW-1:0] avail_a, avail_b, wb_stamp, fwd_stamp, div_busy_until;
    logic          go, fire, q_empty, q_full, q_pop;

    assign slot_cls = d_q.cls;

    issue_scoreboard #(.CW(CW)) u_sb (
        .clk      (clk),
        .rst      (rst),
        .rd_a     (d_q.src_a),
        .rd_b     (d_q.src_b),
        .avail_a  (avail_a),
        .avail_b  (avail_b),
        .wr_en    (go),
        .wr_idx   (d_q.dst),
        .wr_stamp (fwd_stamp)
    );

    issue_hazard #(.CW(CW)) u_hz (
        .slot_valid     (d_valid),
        .slot_cls       (slot_cls),
        .now            (cyc),
        .avail_a        (avail_a),
        .avail_b        (avail_b),
        .div_free_at    (div_free_q),
        .last_wb        (last_wb_q),
        .go             (go),
        .wb_stamp       (wb_stamp),
        .fwd_stamp      (fwd_stamp),
        .div_busy_until (div_busy_until)
    );

    issue_retire_queue #(.CW(CW), .DEPTH(QDEPTH)) u_rq (
        .clk        (clk),
        .rst        (rst),
        .push       (go),
        .push_stamp (wb_stamp),
        .now        (cyc),
        .pop        (q_pop),
        .empty      (q_empty),
        .full       (q_full)
    );

    always_comb begin
        if (last_taken)
            in_ready = 1'b0;
        else if (serial_mode)
            in_ready = !d_valid && q_empty;
        else
            in_ready = !d_valid || go;
    end

    assign fire         = in_valid && in_ready;
    assign issue_pulse  = go;
    assign retire_pulse = q_pop;
    assign cycle_total  = total_q;
    assign done         = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            d_q          <= '0;
            d_valid      <= 1'b0;
            last_taken   <= 1'b0;
            running      <= 1'b0;
            done_q       <= 1'b0;
            cyc          <= '0;
            div_free_q   <= '0;
            last_wb_q    <= '0;
            total_q      <= '0;
            issue_count  <= '0;
            retire_count <= '0;
        end else begin
            if (running || fire)
                cyc <= cyc + CW'(1);
            if (fire)
                running <= 1'b1;
            if (fire) begin
                d_q     <= '{cls: op_class_e'(in_class), dst: in_dst,
                             src_a: in_src_a, src_b: in_src_b};
                d_valid <= 1'b1;
                if (in_last)
                    last_taken <= 1'b1;
            end else if (go) begin
                d_valid <= 1'b0;
            end
            if (go) begin
                last_wb_q   <= wb_stamp;
                total_q     <= wb_stamp + CW'(1);
                issue_count <= issue_count + CW'(1);
                if (slot_cls == OP_DIV)
                    div_free_q <= div_busy_until;
            end
            if (q_pop)
                retire_count <= retire_count + CW'(1);
            if (last_taken && !d_valid && q_empty)
                done_q <= 1'b1;
        end
    end

endmodule

// File: rtl/issue_ctrl_checker.sv
module issue_ctrl_checker
    import issue_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          serial_mode,
    input logic          in_ready,
    input logic          issue_pulse,
    input logic          retire_pulse,
    input logic [CW-1:0] issue_count,
    input logic [CW-1:0] retire_count,
    input logic          done,
    input op_class_e     slot_cls,
    input logic          q_full
);

    logic [2:0] div_gap;

    always_ff @(posedge clk) begin
        if (rst)
            div_gap <= 3'd7;
        else if (issue_pulse && slot_cls == OP_DIV)
            div_gap <= 3'd1;
        else if (div_gap != 3'd7)
            div_gap <= div_gap + 3'd1;
    end

    p_div_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        (issue_pulse && slot_cls == OP_DIV) |-> (div_gap >= 3'd5));

    p_retire_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        retire_count <= issue_count);

    p_retire_in_flight_r6: assert property (@(posedge clk) disable iff (rst)
        retire_pulse |-> (issue_count != retire_count));

    p_no_queue_overrun_r6: assert property (@(posedge clk) disable iff (rst)
        issue_pulse |-> !q_full);

    p_serial_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        (serial_mode && issue_count != retire_count) |-> !in_ready);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    p_closed_after_done_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (!in_ready && !issue_pulse && issue_count == retire_count));

endmodule

bind issue_ctrl issue_ctrl_checker #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .serial_mode  (serial_mode),
    .in_ready     (in_ready),
    .issue_pulse  (issue_pulse),
    .retire_pulse (retire_pulse),
    .issue_count  (issue_count),
    .retire_count (retire_count),
    .done         (done),
    .slot_cls     (slot_cls),
    .q_full       (q_full)
);

// File: tb/issue_ctrl_bench.sv
`timescale 1ns/1ps
module issue_ctrl_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          serial_mode = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_class = '0;
    logic [3:0]    in_dst = '0, in_src_a = '0, in_src_b = '0;
    logic          in_last = 1'b0;
    logic          in_ready, issue_pulse, retire_pulse, done;
    logic [CW-1:0] issue_count, retire_count, cycle_total;

    always #2.5 clk = ~clk;

    issue_ctrl #(.CW(CW), .QDEPTH(8)) u_issue_ctrl (
        .clk(clk), .rst(rst), .serial_mode(serial_mode),
        .in_valid(in_valid), .in_class(in_class), .in_dst(in_dst),
        .in_src_a(in_src_a), .in_src_b(in_src_b), .in_last(in_last),
        .in_ready(in_ready), .issue_pulse(issue_pulse),
        .retire_pulse(retire_pulse), .issue_count(issue_count),
        .retire_count(retire_count), .cycle_total(cycle_total), .done(done)
    );

    int checks = 0;
    int errors = 0;

    // program and model
    int n_ins;
    int p_cls [16];
    int p_dst [16];
    int p_sa  [16];
    int p_sb  [16];
    int m_t   [16];
    int m_wb  [16];
    int m_low;
    // observations
    int obs_iss [16];
    int obs_ret [16];
    int n_iss, n_ret, low_cnt;
    bit run_timeout;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input int c);
        return (c == 1) ? 3 : (c == 2) ? 5 : 1;
    endfunction

    task automatic set_ins(input int k, input int c, input int d, input int a, input int b);
        p_cls[k] = c; p_dst[k] = d; p_sa[k] = a; p_sb[k] = b;
    endtask

    // timing model for the pipelined mode, from the requirements
    task automatic build_model();
        int rdy [16];
        int prev_t, last_wb, div_free, t, l;
        for (int r = 0; r < 16; r++) rdy[r] = 0;
        prev_t = 1; last_wb = 0; div_free = 0; m_low = 0;
        for (int k = 0; k < n_ins; k++) begin
            l = lat_of(p_cls[k]);
            t = prev_t + 1;
            if (rdy[p_sa[k]] > t) t = rdy[p_sa[k]];
            if (rdy[p_sb[k]] > t) t = rdy[p_sb[k]];
            if (p_cls[k] == 2 && div_free > t) t = div_free;
            if (last_wb - l > t) t = last_wb - l;
            if (k < n_ins - 1) m_low += t - prev_t - 1;
            m_t[k] = t;
            m_wb[k] = t + l + 1;
            rdy[p_dst[k]] = t + l + ((p_cls[k] == 3) ? 1 : 0);
            if (p_cls[k] == 2) div_free = t + 5;
            last_wb = m_wb[k];
            prev_t = t;
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        in_last  = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_stream(input bit serial);
        serial_mode = serial;
        do_reset();
        build_model();
        n_iss = 0; n_ret = 0; low_cnt = 0; run_timeout = 1'b0;
        fork
            begin
                for (int k = 0; k < n_ins; k++) begin
                    in_valid = 1'b1;
                    in_class = 2'(p_cls[k]);
                    in_dst   = 4'(p_dst[k]);
                    in_src_a = 4'(p_sa[k]);
                    in_src_b = 4'(p_sb[k]);
                    in_last  = (k == n_ins - 1);
                    while (!in_ready) begin
                        low_cnt++;
                        @(negedge clk);
                    end
                    @(negedge clk);
                end
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            begin
                int guard = 0;
                int ncyc = 0;
                while (!done && guard < 3000) begin
                    @(negedge clk);
                    ncyc++;
                    guard++;
                    if (issue_pulse && n_iss < 16) begin obs_iss[n_iss] = ncyc; n_iss++; end
                    if (retire_pulse && n_ret < 16) begin obs_ret[n_ret] = ncyc; n_ret++; end
                end
                if (!done) run_timeout = 1'b1;
            end
        join
        check("R9", "stream finished", int'(run_timeout), 0);
    endtask

    task automatic check_common(input string tag);
        check("R9", {tag, " issue_count"}, int'(issue_count), n_ins);
        check("R9", {tag, " retire_count"}, int'(retire_count), n_ins);
        check("R9", {tag, " observed issues"}, n_iss, n_ins);
        check("R6", {tag, " observed retires"}, n_ret, n_ins);
        for (int k = 1; k < n_ins && k < n_iss && k < n_ret; k++) begin
            check("R6", {tag, " retire gap"}, obs_ret[k] - obs_ret[k-1], m_wb[k] - m_wb[k-1]);
            check("R7", {tag, " issue gap"}, obs_iss[k] - obs_iss[k-1], m_t[k] - m_t[k-1]);
        end
    endtask

    task automatic t_reset_state();
        serial_mode = 1'b0;
        do_reset();
        check("R1", "in_ready", int'(in_ready), 1);
        check("R1", "issue_pulse", int'(issue_pulse), 0);
        check("R1", "retire_pulse", int'(retire_pulse), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "issue_count", int'(issue_count), 0);
        check("R1", "retire_count", int'(retire_count), 0);
    endtask

    task automatic t_alu_stream();
        n_ins = 6;
        for (int k = 0; k < 6; k++) set_ins(k, 0, k + 1, 10, 11);
        run_stream(1'b0);
        check_common("alu");
        check("R2", "alu total", int'(cycle_total), 10);
        for (int k = 1; k < n_iss; k++)
            check("R2", "alu issue spacing", obs_iss[k] - obs_iss[k-1], 1);
    endtask

    task automatic t_mul_stream();
        n_ins = 4;
        for (int k = 0; k < 4; k++) set_ins(k, 1, k + 1, 12, 13);
        run_stream(1'b0);
        check_common("mul");
        check("R3", "mul total", int'(cycle_total), 10);
        for (int k = 1; k < n_iss; k++)
            check("R3", "mul issue spacing", obs_iss[k] - obs_iss[k-1], 1);
    endtask

    task automatic t_div_pair();
        n_ins = 3;
        set_ins(0, 2, 1, 2, 3);
        set_ins(1, 2, 4, 5, 6);
        set_ins(2, 0, 7, 8, 9);
        run_stream(1'b0);
        check_common("div");
        check("R4", "div-div spacing", obs_iss[1] - obs_iss[0], 5);
        check("R7", "stalled fetch cycles", low_cnt, 4);
        check("R7", "stalled fetch model", low_cnt, m_low);
        check("R9", "div total", int'(cycle_total), 15);
    endtask

    task automatic t_raw();
        n_ins = 4;
        set_ins(0, 1, 1, 2, 3);
        set_ins(1, 0, 4, 1, 5);
        set_ins(2, 3, 6, 7, 7);
        set_ins(3, 0, 8, 6, 0);
        run_stream(1'b0);
        check_common("raw");
        check("R5", "mul->use gap", obs_iss[1] - obs_iss[0], 3);
        check("R5", "load->use gap", obs_iss[3] - obs_iss[2], 2);
    endtask

    task automatic t_in_order();
        n_ins = 2;
        set_ins(0, 1, 1, 2, 3);
        set_ins(1, 0, 4, 5, 6);
        run_stream(1'b0);
        check_common("order");
        check("R6", "alu held behind mul", obs_iss[1] - obs_iss[0], 3);
        check("R6", "back-to-back retire", obs_ret[1] - obs_ret[0], 1);
    endtask

    task automatic load_mixed();
        n_ins = 10;
        set_ins(0, 1, 1, 2, 3);
        set_ins(1, 2, 4, 1, 6);
        set_ins(2, 3, 9, 4, 4);
        set_ins(3, 1, 2, 1, 3);
        set_ins(4, 3, 3, 2, 2);
        set_ins(5, 1, 4, 3, 6);
        set_ins(6, 3, 5, 4, 4);
        set_ins(7, 1, 7, 8, 9);
        set_ins(8, 2, 4, 10, 4);
        set_ins(9, 0, 8, 9, 11);
    endtask

    task automatic t_mixed_pipelined();
        load_mixed();
        run_stream(1'b0);
        check_common("mixed");
        check("R9", "mixed total", int'(cycle_total), m_wb[n_ins-1] + 1);
        check("R7", "mixed stalled fetch", low_cnt, m_low);
        // R10: closed after the last instruction
        repeat (3) @(negedge clk);
        check("R10", "done holds", int'(done), 1);
        check("R10", "ready stays low", int'(in_ready), 0);
    endtask

    task automatic t_serial();
        int sum = 0;
        load_mixed();
        for (int k = 0; k < n_ins; k++) sum += 4 + lat_of(p_cls[k]);
        run_stream(1'b1);
        check("R8", "serial total", int'(cycle_total), sum);
        check("R8", "serial total value", int'(cycle_total), 66);
        check("R8", "serial issues", int'(issue_count), n_ins);
        check("R8", "serial retires", int'(retire_count), n_ins);
    endtask

    initial begin : watchdog
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                checks++;
                errors++;
                $display("FAIL R9 watchdog: actual=%0d expected<=%0d", wd, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        t_reset_state();
        t_alu_stream();
        t_mul_stream();
        t_div_pair();
        t_raw();
        t_in_order();
        t_mixed_pipelined();
        t_serial();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule